// File: doc/BRIEF.md
# IR pulse-width capture receiver

This block takes a demodulated infrared receiver line, where high means a mark, and measures the alternating marks and spaces of a remote-control message. A programmable divider of the system clock produces a sample tick. The input passes through a two-flop synchronizer and a de-glitch filter. Each mark and space is then counted in sample periods and stored as an 8-bit width. The widths are packed four per 32-bit capture word, in a store of 17 words, which holds up to 68 widths.

A message ends in one of two ways. The first is a space that saturates at 255 samples, followed by a programmable tail of idle samples. The second is a full store. In either case the block latches a pending flag, and the level interrupt follows that flag when it is enabled. Software reads the capture words and clears the interrupt. It then writes the restart strobe, which empties the store and rearms the receiver for the next message.

Top module: `irpw_rx`

## Requirements
- R1: Sample ticks, and with them capture, happen only while both the run bit (bit 0) and the width-detect bit (bit 13) of the control register (0x00) are set. With either bit clear, the input changes nothing.
- R2: Widths are stored in arrival order. Width k goes to the word at byte address 0x40 + 4*(k/4), in bits 8*(k%4)+7 : 8*(k%4). The first width is a mark, and the widths that follow alternate space, mark, space and so on.
- R3: Each width equals the number of sample ticks spent at that level. A mark saturates at 0xFF and does not end the message.
- R4: A space that reaches 255 samples is stored as 0xFF. After a further tail of N+1 sample ticks, where N is the control field in bits 31:24 (reset value 0x0F), the pending flag sets.
- R5: A level change is accepted only after the new level has been seen on D consecutive sample ticks. D is the filter register (0x08) field in bits 12:8, with reset value 1, and a value of 0 acts as 1. Shorter glitches are absorbed into the surrounding width.
- R6: Writing 1 to bit 0 of the restart register (0x0C) zeroes every capture word and returns the receiver to idle. A new capture starts only on a rising mark edge seen while idle, so a mark already present at restart is not recorded.
- R7: When the 68th width is stored, the pending flag sets at once and the message ends.
- R8: irq_o is high when the pending flag and the enable bit (bit 0 of 0x10) are both set. Writing 1 to bit 0 of 0x14 clears the pending flag, unless completion occurs in the same cycle, in which case completion wins. Reading 0x14 returns the pending flag in bit 0.
- R9: After completion, input edges are ignored until a restart. Width fields never written read as zero.
- R10: One sample tick occurs every P clocks, where P is the divider register (0x04, 24 bits, reset 2300, which is 46 us at 50 MHz) and a value of 0 acts as 1.
- R11: The input reaches the filter through two synchronizing flops, so every width and the completion time follow the input with a fixed delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_i | input | 1 | Demodulated IR line, high = mark |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register read byte address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a completely full store. It takes 68 accepted edges with no space long enough to end the message early. The stimulus gets there with a train of 34 short mark and space pairs plus a closing mark, at a small divider, so that the final store write and the immediate completion both happen. A second hard case is a glitch shorter than the de-glitch count in the middle of a mark, which must merge into one width. A behavioural model in the bench follows the sampling, filtering and capture on every clock. It compares the interrupt each cycle and the capture words after each message, and fixed expected widths are checked alongside the model.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_RUN  = 2'd1,
        CAP_TAIL = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;

    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_DIV     = 8'h04;
    localparam logic [7:0] A_FILT    = 8'h08;
    localparam logic [7:0] A_RESTART = 8'h0C;
    localparam logic [7:0] A_IEN     = 8'h10;
    localparam logic [7:0] A_ICLR    = 8'h14;
    localparam logic [7:0] A_CAP     = 8'h40;
endpackage

// File: rtl/irpw_tick_gen.sv
module irpw_tick_gen #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DIV_W-1:0] period;

    always_comb begin
        period = (div_i == '0) ? DIV_W'(1) : div_i;
        tick_o = en_i && (st_q.cnt >= period - DIV_W'(1));
        st_d   = st_q;
        if (!en_i || tick_o) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irpw_sync_filter.sv
module irpw_sync_filter #(
    parameter int DG_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din_i,
    input  logic            tick_i,
    input  logic [DG_W-1:0] dg_i,
    output logic            level_o
);
    typedef struct packed {
        logic            s1;
        logic            s2;
        logic            lvl;
        logic [DG_W-1:0] run;
    } st_t;

    st_t st_d, st_q;
    logic [DG_W:0] need;
    logic [DG_W:0] seen;

    always_comb begin
        need  = (dg_i == '0) ? (DG_W+1)'(1) : {1'b0, dg_i};
        seen  = {1'b0, st_q.run} + (DG_W+1)'(1);
        st_d    = st_q;
        st_d.s1 = din_i;
        st_d.s2 = st_q.s1;
        if (tick_i) begin
            if (st_q.s2 != st_q.lvl) begin
                if (seen >= need) begin
                    st_d.lvl = st_q.s2;
                    st_d.run = '0;
                end else begin
                    st_d.run = seen[DG_W-1:0];
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    assign level_o = st_q.lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irpw_capture_core.sv
module irpw_capture_core
    import irpw_pkg::*;
#(
    parameter int NUM_WORDS = 17,
    parameter int ENTRY_W   = 8,
    localparam int PER_WORD = 32 / ENTRY_W,
    localparam int NUM_ENT  = NUM_WORDS * PER_WORD,
    localparam int IDX_W    = $clog2(NUM_ENT + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_i,
    input  logic                              level_i,
    input  logic                              restart_i,
    input  logic [7:0]                        tail_i,
    output logic [NUM_ENT-1:0][ENTRY_W-1:0]   ent_o,
    output cap_state_e                        state_o,
    output logic [IDX_W-1:0]                  idx_o,
    output logic                              done_o
);
    localparam logic [ENTRY_W-1:0] WMAX = '1;
    localparam logic [IDX_W-1:0]   LAST = IDX_W'(NUM_ENT - 1);

    typedef struct packed {
        cap_state_e                       st;
        logic [IDX_W-1:0]                 idx;
        logic [ENTRY_W-1:0]               cnt;
        logic [7:0]                       tcnt;
        logic                             lvl;
        logic [NUM_ENT-1:0][ENTRY_W-1:0]  ent;
    } st_t;

    st_t st_d, st_q;
    logic [ENTRY_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        done_o  = 1'b0;
        cnt_inc = (st_q.cnt == WMAX) ? WMAX : st_q.cnt + ENTRY_W'(1);
        if (restart_i) begin
            st_d.st   = CAP_IDLE;
            st_d.idx  = '0;
            st_d.cnt  = '0;
            st_d.tcnt = '0;
            st_d.lvl  = 1'b1;
            st_d.ent  = '0;
        end else if (tick_i) begin
            case (st_q.st)
                CAP_IDLE: begin
                    if (level_i && !st_q.lvl) begin
                        st_d.st  = CAP_RUN;
                        st_d.cnt = ENTRY_W'(1);
                    end
                    st_d.lvl = level_i;
                end
                CAP_RUN: begin
                    if (level_i != st_q.lvl) begin
                        st_d.ent[st_q.idx] = st_q.cnt;
                        st_d.idx = st_q.idx + IDX_W'(1);
                        st_d.lvl = level_i;
                        st_d.cnt = ENTRY_W'(1);
                        if (st_q.idx == LAST) begin
                            st_d.st = CAP_DONE;
                            done_o  = 1'b1;
                        end
                    end else begin
                        st_d.cnt = cnt_inc;
                        if (!st_q.lvl && cnt_inc == WMAX) begin
                            st_d.ent[st_q.idx] = WMAX;
                            st_d.idx  = st_q.idx + IDX_W'(1);
                            st_d.tcnt = '0;
                            if (st_q.idx == LAST) begin
                                st_d.st = CAP_DONE;
                                done_o  = 1'b1;
                            end else begin
                                st_d.st = CAP_TAIL;
                            end
                        end
                    end
                end
                CAP_TAIL: begin
                    if (st_q.tcnt == tail_i) begin
                        st_d.st = CAP_DONE;
                        done_o  = 1'b1;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ent_o   = st_q.ent;
    assign state_o = st_q.st;
    assign idx_o   = st_q.idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.st  <= CAP_IDLE;
            st_q.lvl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irpw_rx.sv
module irpw_rx
    import irpw_pkg::*;
#(
    parameter int               NUM_WORDS  = 17,
    parameter int               DIV_W      = 24,
    parameter int               DG_W       = 5,
    parameter logic [DIV_W-1:0] DIV_RESET  = DIV_W'(2300),
    parameter logic [7:0]       TAIL_RESET = 8'h0F,
    parameter logic [DG_W-1:0]  DG_RESET   = DG_W'(1),
    localparam int ENTRY_W = 8,
    localparam int NUM_ENT = NUM_WORDS * 4,
    localparam int IDX_W   = $clog2(NUM_ENT + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [7:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        irq_o
);
    typedef struct packed {
        logic             run;
        logic             wde;
        logic [7:0]       tail;
        logic [DIV_W-1:0] div;
        logic [DG_W-1:0]  dg;
        logic             ien;
        logic             pend;
    } regs_t;

    regs_t reg_d, reg_q;

    logic restart_pulse, clr_pulse, done_pulse, tick, level;
    logic [NUM_ENT-1:0][ENTRY_W-1:0] ent;
    cap_state_e       cap_st;
    logic [IDX_W-1:0] cap_idx;

    assign restart_pulse = wr_en_i && (wr_addr_i == A_RESTART) && wr_data_i[0];
    assign clr_pulse     = wr_en_i && (wr_addr_i == A_ICLR) && wr_data_i[0];

    always_comb begin
        reg_d = reg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: begin
                    reg_d.run  = wr_data_i[0];
                    reg_d.wde  = wr_data_i[13];
                    reg_d.tail = wr_data_i[31:24];
                end
                A_DIV:  reg_d.div = wr_data_i[DIV_W-1:0];
                A_FILT: reg_d.dg  = wr_data_i[8 +: DG_W];
                A_IEN:  reg_d.ien = wr_data_i[0];
                default: ;
            endcase
        end
        if (done_pulse)     reg_d.pend = 1'b1;
        else if (clr_pulse) reg_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q      <= '0;
            reg_q.tail <= TAIL_RESET;
            reg_q.div  <= DIV_RESET;
            reg_q.dg   <= DG_RESET;
        end else begin
            reg_q <= reg_d;
        end
    end

    irpw_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (reg_q.run && reg_q.wde),
        .div_i  (reg_q.div),
        .tick_o (tick)
    );

    irpw_sync_filter #(.DG_W(DG_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   (ir_i),
        .tick_i  (tick),
        .dg_i    (reg_q.dg),
        .level_o (level)
    );

    irpw_capture_core #(.NUM_WORDS(NUM_WORDS), .ENTRY_W(ENTRY_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .level_i   (level),
        .restart_i (restart_pulse),
        .tail_i    (reg_q.tail),
        .ent_o     (ent),
        .state_o   (cap_st),
        .idx_o     (cap_idx),
        .done_o    (done_pulse)
    );

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL:  rd_data_o = {reg_q.tail, 10'd0, reg_q.wde, 12'd0, reg_q.run};
            A_DIV:   rd_data_o = 32'(reg_q.div);
            A_FILT:  rd_data_o = 32'({reg_q.dg, 8'd0});
            A_IEN:   rd_data_o = {31'd0, reg_q.ien};
            A_ICLR:  rd_data_o = {31'd0, reg_q.pend};
            default: ;
        endcase
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_addr_i == 8'(int'(A_CAP) + 4 * w)) rd_data_o = ent[4*w +: 4];
        end
    end

    assign irq_o = reg_q.pend && reg_q.ien;
endmodule

// File: rtl/irpw_checks.sv
module irpw_checks
    import irpw_pkg::*;
#(
    parameter int NUM_ENT = 68,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             restart,
    input logic             clr,
    input logic             done,
    input logic             pend,
    input cap_state_e       st,
    input logic [IDX_W-1:0] idx
);
    // R6: restart empties the store and returns to idle
    a_r6_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st == CAP_IDLE && idx == '0));
    // R7: the fill index never passes the store size
    a_r7_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(NUM_ENT));
    // R9: completion holds until restart
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_DONE && !restart) |=> st == CAP_DONE);
    // R8: clear drops pending when no completion competes
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> !pend);
    // R4: completion latches pending
    a_r4_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> pend);
    // R1: without a sample tick the capture state does not move
    a_r1_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(idx) && $stable(st)));
    // R2: widths are appended one at a time
    a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (idx == $past(idx) || idx == $past(idx) + IDX_W'(1)));
endmodule

bind irpw_rx irpw_checks #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart_pulse),
    .clr     (clr_pulse),
    .done    (done_pulse),
    .pend    (reg_q.pend),
    .st      (cap_st),
    .idx     (cap_idx)
);

// File: tb/test_irpw_rx.sv
module test_irpw_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irpw_rx i_irpw_rx (
        .clk(clk), .rst_n(rst_n), .ir_i(ir), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_run, m_wde, m_tail, m_div, m_dg, m_ien, m_pend;
    int m_dc, m_s1, m_s2, m_f, m_fr;
    int m_st, m_idx, m_cnt, m_tc, m_lvl;
    int m_ent[68];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_wde = 0; m_tail = 15; m_div = 2300; m_dg = 1;
            m_ien = 0; m_pend = 0; m_dc = 0; m_s1 = 0; m_s2 = 0; m_f = 0; m_fr = 0;
            m_st = 0; m_idx = 0; m_cnt = 0; m_tc = 0; m_lvl = 1;
            foreach (m_ent[k]) m_ent[k] = 0;
        end else begin
            int en, per, tk, rs, cl, fin, need, nx;
            en  = m_run && m_wde;
            per = (m_div == 0) ? 1 : m_div;
            tk  = en && (m_dc >= per - 1);
            rs  = wr_en && wr_addr == 8'h0C && wr_data[0];
            cl  = wr_en && wr_addr == 8'h14 && wr_data[0];
            fin = 0;
            if (rs) begin
                m_st = 0; m_idx = 0; m_cnt = 0; m_tc = 0; m_lvl = 1;
                foreach (m_ent[k]) m_ent[k] = 0;
            end else if (tk) begin
                if (m_st == 0) begin
                    if (m_f == 1 && m_lvl == 0) begin m_st = 1; m_cnt = 1; end
                    m_lvl = m_f;
                end else if (m_st == 1) begin
                    if (m_f != m_lvl) begin
                        m_ent[m_idx] = m_cnt; m_idx++; m_lvl = m_f; m_cnt = 1;
                        if (m_idx == 68) begin m_st = 3; fin = 1; end
                    end else begin
                        nx = (m_cnt >= 255) ? 255 : m_cnt + 1;
                        m_cnt = nx;
                        if (m_lvl == 0 && nx == 255) begin
                            m_ent[m_idx] = 255; m_idx++; m_tc = 0;
                            if (m_idx == 68) begin m_st = 3; fin = 1; end
                            else m_st = 2;
                        end
                    end
                end else if (m_st == 2) begin
                    if (m_tc == m_tail) begin m_st = 3; fin = 1; end
                    else m_tc++;
                end
            end
            if (fin) m_pend = 1;
            else if (cl) m_pend = 0;
            if (tk) begin
                need = (m_dg == 0) ? 1 : m_dg;
                if (m_s2 != m_f) begin
                    if (m_fr + 1 >= need) begin m_f = m_s2; m_fr = 0; end
                    else m_fr++;
                end else m_fr = 0;
            end
            m_s2 = m_s1; m_s1 = ir;
            m_dc = (!en || tk) ? 0 : m_dc + 1;
            if (wr_en) begin
                case (wr_addr)
                    8'h00: begin m_run = wr_data[0]; m_wde = wr_data[13]; m_tail = wr_data[31:24]; end
                    8'h04: m_div = wr_data[23:0];
                    8'h08: m_dg = wr_data[12:8];
                    8'h10: m_ien = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    // R4 R11: interrupt compared against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (irq !== (m_pend && m_ien)) begin
                failures++;
                $display("FAIL R4 R11 irq per-clock at %0t: actual=%0b expected=%0b",
                         $time, irq, (m_pend && m_ien));
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_addr = a; #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s addr=%02h: actual=%08h expected=%08h", tag, a, rd_data, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk); #1;
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq: actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int ticks);
        @(negedge clk); ir = lvl;
        repeat (ticks * 4 - 1) @(negedge clk);
    endtask

    task automatic model_words(input string tag);
        for (int w = 0; w < 17; w++) begin
            logic [31:0] e;
            e = {m_ent[4*w+3][7:0], m_ent[4*w+2][7:0], m_ent[4*w+1][7:0], m_ent[4*w][7:0]};
            rd_chk(8'(8'h40 + 4 * w), e, {tag, " model words"});
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state, R10 default divider
        rd_chk(8'h00, 32'h0F00_0000, "R1 reset ctrl");
        rd_chk(8'h04, 32'd2300, "R10 reset divider");
        rd_chk(8'h08, 32'h0000_0100, "R5 reset filter");
        rd_chk(8'h40, 32'h0, "R9 reset word0");
        irq_chk(1'b0, "R8 reset");

        wr(8'h04, 32'd4);
        wr(8'h10, 32'd1);
        // R1: run bit only, width-detect clear: nothing captured
        wr(8'h00, 32'h0200_0001);
        drive(0, 5); drive(1, 6); drive(0, 6); drive(1, 6); drive(0, 20);
        rd_chk(8'h40, 32'h0, "R1 disabled capture");
        irq_chk(1'b0, "R1 disabled");

        // message A: R2 R3 R4 R10
        wr(8'h00, 32'h0200_2001);
        drive(0, 5); drive(1, 10); drive(0, 5); drive(1, 3); drive(0, 7);
        drive(1, 300); drive(0, 300);
        rd_chk(8'h40, 32'h0703_050A, "R2 R3 R10 packing");
        rd_chk(8'h44, 32'h0000_FFFF, "R3 R4 saturation");
        irq_chk(1'b1, "R4 completion");
        // R9: edges after completion ignored
        drive(1, 5); drive(0, 5); drive(1, 5); drive(0, 5);
        rd_chk(8'h44, 32'h0000_FFFF, "R9 ignored after done");
        rd_chk(8'h48, 32'h0, "R9 unused zero");
        model_words("R2");
        // R8
        wr(8'h10, 32'd0);
        irq_chk(1'b0, "R8 enable off");
        rd_chk(8'h14, 32'd1, "R8 pending kept");
        wr(8'h10, 32'd1);
        irq_chk(1'b1, "R8 enable on");
        wr(8'h14, 32'd1);
        irq_chk(1'b0, "R8 clear");

        // R6: restart while a mark is held
        drive(1, 3);
        wr(8'h0C, 32'd1);
        rd_chk(8'h40, 32'h0, "R6 restart clears");
        drive(1, 5); drive(0, 4); drive(1, 6); drive(0, 300);
        rd_chk(8'h40, 32'h0000_FF06, "R6 start on rising edge");
        model_words("R6");
        wr(8'h14, 32'd1);

        // R5: de-glitch count 3
        wr(8'h08, 32'h0000_0300);
        wr(8'h0C, 32'd1);
        drive(0, 4); drive(1, 8); drive(0, 2); drive(1, 8); drive(0, 4);
        drive(1, 5); drive(0, 300);
        rd_chk(8'h40, 32'hFF05_0412, "R5 glitch absorbed");
        model_words("R5");
        wr(8'h14, 32'd1);

        // R7: full store
        wr(8'h08, 32'h0000_0100);
        wr(8'h0C, 32'd1);
        drive(0, 4);
        for (int p = 0; p < 34; p++) begin drive(1, 2); drive(0, 2); end
        drive(1, 2); drive(0, 10);
        irq_chk(1'b1, "R7 full completion");
        rd_chk(8'h40, 32'h0202_0202, "R7 first word");
        rd_chk(8'h80, 32'h0202_0202, "R7 last word");
        drive(1, 4); drive(0, 4);
        rd_chk(8'h80, 32'h0202_0202, "R7 R9 no overflow");
        model_words("R7");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule